// File: doc/BRIEF.md
# Cluster Coherency Control Register Block

This block is the register slave of a cluster coherency unit. It occupies a 256-byte window and holds an enable bit for the unit, a read-only word that reports how many processor cores the cluster has, and a 32-bit word of per-core power state. A small set of offsets are reserved: they read back as zero and drop writes. Requests may be 1, 2 or 4 bytes wide and may start at any byte offset.

For the power word, a request at offset 0x08+k works on lane k. A read returns the word shifted down by k bytes. A write replaces only the bytes covered by the access size, starting at lane k. Any bytes that would fall past the top of the word are discarded.

A request is presented for one cycle with `req_valid_i` high. The block has no back-pressure: it accepts a request in every cycle that `req_valid_i` is high, and a requester may issue back to back. A read is answered exactly one cycle later by a `rsp_valid_o` pulse that carries the data, and the response cannot be stalled. A write produces no response. A write with an illegal size instead raises `size_err_o` for one cycle.

Top module: `snoop_ctl_regs`

## Requirements
- R1: After reset the enable bit and the power word are zero, and `rsp_valid_o` and `size_err_o` are low.
- R2: A write at offset 0x00 of any legal size stores bit 0 of the data as the enable bit. A read at 0x00 returns that bit in bit 0 with bits 31:1 zero.
- R3: Offset 0x04 is read-only. It reads (2^N − 1) << 4 ORed with N − 1, where N is the core-count parameter (1 to 4; 0xF3 for N = 4). Writes to it have no effect.
- R4: A read at offset 0x08+k (k = 0..3) returns the power word shifted right by 8·k bits.
- R5: A legal write at 0x08+k clears the bits selected by (size mask << 8·k), truncated to 32 bits, and loads them from (data << 8·k). All other bits of the power word keep their value.
- R6: `req_size_i` gives the byte count. 1 selects mask 0xFF, 2 selects 0xFFFF and 4 selects 0xFFFFFFFF. A write with any other size changes no register and raises `size_err_o` for exactly one cycle, one cycle after the request. For a read, the size does not affect the returned data.
- R7: Offset 0x0C, the reserved offsets 0x40, 0x44, 0x50 and 0x54, and every other offset not named in R2 to R5 read as zero. Writes to them change neither the enable bit nor the power word.
- R8: `rsp_valid_o` is high for exactly the one cycle after each read request, carrying that read's data, and stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 8 | Byte offset in the window |
| req_size_i | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Read response data |
| size_err_o | output | 1 | One-cycle pulse after an illegal-size write |

## Verification
The hardest case to reach is a multi-byte write that starts in an upper lane, so that part of its mask runs past bit 31. A related hard case is an illegal-size write that must leave every byte untouched. A wrong lane shift or mask only shows up if the power word already holds distinct bytes in every lane. The stimulus therefore first loads a full, byte-distinct pattern. It then issues unaligned 2- and 4-byte writes at lanes 1 to 3, and writes with sizes 0, 3, 5 and 7. After each one it reads all four lanes back.

// File: rtl/snoop_ctl_pkg.sv
package snoop_ctl_pkg;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_CFG  = 2'd1,
    RG_PWR  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_PWR  = 8'h08;

endpackage

// File: rtl/snoop_ctl_decode.sv
module snoop_ctl_decode
  import snoop_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] off_i,
  output region_e           region_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] PWR_A  = ADDR_W'(OFF_PWR);

  always_comb begin
    lane_o = off_i[LANE_W-1:0];
    if (off_i == CTRL_A)
      region_o = RG_CTRL;
    else if (off_i == CFG_A)
      region_o = RG_CFG;
    else if (off_i[ADDR_W-1:LANE_W] == PWR_A[ADDR_W-1:LANE_W])
      region_o = RG_PWR;
    else
      region_o = RG_NONE;
  end
endmodule

// File: rtl/snoop_ctl_size.sv
module snoop_ctl_size #(
  parameter int BYTES = 4
) (
  input  logic [2:0]       size_i,
  output logic             legal_o,
  output logic [BYTES-1:0] be_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (size_i)
      3'd1:    be_o = BYTES'(1);
      3'd2:    be_o = BYTES'(3);
      3'd4:    be_o = BYTES'(15);
      default: begin
        be_o    = '0;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/snoop_ctl_pwr.sv
module snoop_ctl_pwr #(
  parameter int BYTES  = 4,
  parameter int LANE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [LANE_W-1:0]  lane_i,
  input  logic [BYTES-1:0]   be_i,
  input  logic [8*BYTES-1:0] wdata_i,
  output logic [8*BYTES-1:0] word_o
);
  logic [BYTES-1:0]   be_sh;
  logic [8*BYTES-1:0] data_sh;

  assign be_sh   = be_i << lane_i;
  assign data_sh = wdata_i << {lane_i, 3'b000};

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_o[8*b +: 8] <= 8'h00;
      else if (wr_en_i && be_sh[b])
        word_o[8*b +: 8] <= data_sh[8*b +: 8];
    end
  end

  // R5
  pwr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(word_o));
endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import snoop_ctl_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_off_i,
  input  logic [2:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              size_err_o
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'((((1 << N_CORES) - 1) << 4) | (N_CORES - 1));

  if (N_CORES < 1 || N_CORES > 4) begin : g_bad_cores
    $error("N_CORES must lie in 1..4");
  end

  region_e           region;
  logic [LANE_W-1:0] lane;
  logic              size_ok;
  logic [BYTES-1:0]  be;
  logic              ctrl_q;
  logic [DATA_W-1:0] pwr_word;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok;

  snoop_ctl_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dec (
    .off_i(req_off_i), .region_o(region), .lane_o(lane));

  snoop_ctl_size #(.BYTES(BYTES)) u_size (
    .size_i(req_size_i), .legal_o(size_ok), .be_o(be));

  assign wr_ok = req_valid_i && req_write_i && size_ok;

  snoop_ctl_pwr #(.BYTES(BYTES), .LANE_W(LANE_W)) u_pwr (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_ok && region == RG_PWR),
    .lane_i(lane), .be_i(be), .wdata_i(req_wdata_i),
    .word_o(pwr_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= 1'b0;
    else if (wr_ok && region == RG_CTRL)
      ctrl_q <= req_wdata_i[0];
  end

  always_comb begin
    unique case (region)
      RG_CTRL: rd_mux = DATA_W'(ctrl_q);
      RG_CFG:  rd_mux = CFG_WORD;
      RG_PWR:  rd_mux = pwr_word >> {lane, 3'b000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      size_err_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      size_err_o  <= req_valid_i && req_write_i && !size_ok;
    end
  end

  // R6
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && !size_ok) |=> size_err_o);
  // R6
  bad_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && !size_ok) |=> ($stable(pwr_word) && $stable(ctrl_q)));
  // R8
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));
  // R2
  ctrl_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && region == RG_CTRL) |=> (rsp_rdata_o[DATA_W-1:1] == '0));
  // R7
  raz_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && region == RG_NONE) |=> (rsp_rdata_o == '0));
  // R7
  raz_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && region == RG_NONE) |=> ($stable(pwr_word) && $stable(ctrl_q)));
endmodule

// File: tb/sim_snoop_ctl_regs.sv
module sim_snoop_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        size_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_st = '0;
  logic        exp_ctrl = 1'b0;

  always #4 clk = ~clk;

  snoop_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .size_err_o(size_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the response sampled.
  task automatic access(input bit wr, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic rv, output logic er);
    req_valid = 1'b1; req_write = wr; req_off = off; req_size = sz; req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata; rv = rsp_valid; er = size_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d,
                        input string req);
    logic [31:0] rd; logic rv, er;
    access(1'b1, off, sz, d, rd, rv, er);
    chk(req, {31'b0, rv}, 32'd0);
  endtask

  task automatic rd_reg(input logic [7:0] off, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic rv, er;
    access(1'b0, off, 3'd4, '0, rd, rv, er);
    chk({req, " valid"}, {31'b0, rv}, 32'd1);
    chk(req, rd, exp);
  endtask

  function automatic logic [31:0] model_wr(input logic [31:0] st, input int k,
                                           input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] m;
    m = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (st & ~(m << (8 * k))) | ((d & m) << (8 * k));
  endfunction

  task automatic check_all_lanes(input string req);
    for (int k = 0; k < 4; k++) rd_reg(8'h08 + 8'(k), exp_st >> (8 * k), req);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 size_err", {31'b0, size_err}, 32'd0);
    rd_reg(8'h00, 32'd0, "R1 ctrl");
    rd_reg(8'h08, 32'd0, "R1 pwr");
  endtask

  task automatic t_control;
    wr_reg(8'h00, 3'd4, 32'hFFFF_FFFF, "R2 wr");
    rd_reg(8'h00, 32'd1, "R2 set");
    wr_reg(8'h00, 3'd4, 32'hFFFF_FFFE, "R2 wr");
    rd_reg(8'h00, 32'd0, "R2 clear by bit0");
    wr_reg(8'h00, 3'd1, 32'h03, "R2 wr");
    rd_reg(8'h00, 32'd1, "R2 byte write");
    exp_ctrl = 1'b1;
  endtask

  task automatic t_config;
    rd_reg(8'h04, 32'h0000_00F3, "R3 cfg");
    wr_reg(8'h04, 3'd4, 32'h0000_0000, "R3 wr");
    rd_reg(8'h04, 32'h0000_00F3, "R3 read-only");
  endtask

  task automatic t_status;
    wr_reg(8'h08, 3'd4, 32'h1122_3344, "R5 wr");
    exp_st = 32'h1122_3344;
    check_all_lanes("R4 lane read");
    wr_reg(8'h09, 3'd1, 32'hFFFF_FFA5, "R5 wr");
    exp_st = model_wr(exp_st, 1, 3'd1, 32'hFFFF_FFA5);
    chk("R5 model", exp_st, 32'h1122_A544);
    check_all_lanes("R5 byte lane1");
    wr_reg(8'h0A, 3'd2, 32'h1234_BEEF, "R5 wr");
    exp_st = model_wr(exp_st, 2, 3'd2, 32'h1234_BEEF);
    check_all_lanes("R5 half lane2");
    wr_reg(8'h0B, 3'd4, 32'h1234_5678, "R5 wr");
    exp_st = model_wr(exp_st, 3, 3'd4, 32'h1234_5678);
    chk("R5 model top", exp_st, 32'h78EF_A544);
    check_all_lanes("R5 word lane3 truncated");
    wr_reg(8'h09, 3'd4, 32'hCAFE_D00D, "R5 wr");
    exp_st = model_wr(exp_st, 1, 3'd4, 32'hCAFE_D00D);
    check_all_lanes("R5 word lane1");
  endtask

  task automatic t_bad_size;
    logic [31:0] rd; logic rv, er;
    logic [2:0] bad [4] = '{3'd0, 3'd3, 3'd5, 3'd7};
    foreach (bad[i]) begin
      access(1'b1, 8'h08, bad[i], 32'h0, rd, rv, er);
      chk("R6 err pulse", {31'b0, er}, 32'd1);
      chk("R6 no rsp", {31'b0, rv}, 32'd0);
      @(negedge clk);
      chk("R6 err one cycle", {31'b0, size_err}, 32'd0);
      access(1'b1, 8'h00, bad[i], 32'h0, rd, rv, er);
      chk("R6 err ctrl", {31'b0, er}, 32'd1);
    end
    check_all_lanes("R6 pwr unchanged");
    rd_reg(8'h00, {31'b0, exp_ctrl}, "R6 ctrl unchanged");
    access(1'b0, 8'h08, 3'd0, 32'h0, rd, rv, er);
    chk("R6 read ignores size", rd, exp_st);
    chk("R6 read no err", {31'b0, er}, 32'd0);
  endtask

  task automatic t_raz;
    logic [7:0] offs [8] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'h07, 8'hFC};
    foreach (offs[i]) begin
      wr_reg(offs[i], 3'd4, 32'h0000_0000, "R7 wr");
      rd_reg(offs[i], 32'd0, "R7 raz");
    end
    check_all_lanes("R7 pwr untouched");
    rd_reg(8'h00, {31'b0, exp_ctrl}, "R7 ctrl untouched");
  endtask

  task automatic t_timing;
    logic [31:0] rd; logic rv, er;
    access(1'b0, 8'h04, 3'd4, '0, rd, rv, er);
    chk("R8 read valid", {31'b0, rv}, 32'd1);
    @(negedge clk);
    chk("R8 idle no valid", {31'b0, rsp_valid}, 32'd0);
    access(1'b1, 8'h00, 3'd4, 32'd1, rd, rv, er);
    chk("R8 write no valid", {31'b0, rv}, 32'd0);
    req_valid = 1'b1; req_write = 1'b0; req_off = 8'h08; req_size = 3'd4;
    @(negedge clk);
    chk("R8 b2b first", rsp_rdata, exp_st);
    req_off = 8'h04;
    @(negedge clk);
    chk("R8 b2b second", rsp_rdata, 32'h0000_00F3);
    chk("R8 b2b valid", {31'b0, rsp_valid}, 32'd1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control();
    t_config();
    t_status();
    t_bad_size();
    t_raz();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule